// File: doc/BRIEF.md
# Compare Output Waveform Unit

This unit owns a single waveform output bit that follows compare-match pulses from an associated counter. The counter is not part of the unit. A two-bit action code decides what each match does to the stored output level: keep it, invert it, drive it low or drive it high. The action code changes nothing about how the counter counts. A software-style write strobe loads the code. The code is used from the cycle after the write onward, so it governs the first match that arrives after it is written.

A force strobe applies the stored action at once, without a real match, while the counter runs in a non-PWM mode. An indication input reports when the counter is in a PWM mode. The force strobe is then ignored. A preload write sets the stored level directly. This allows the level to be prepared before the pin is enabled. A direction input decides whether the stored level reaches the pin or the pin is marked as not driven.

Top module: `cmp_wave_out`

## Requirements
- R1: After reset the stored output level is 0 and the stored action code is 00 (keep), so pin_o reads 0 whatever the direction.
- R2: With action code 00 stored, a match (match_i = 1) leaves the stored level unchanged.
- R3: On a match the stored code 01 inverts the level, 10 makes it 0 and 11 makes it 1. The new level is visible on pin_o after the clock edge that samples the match.
- R4: A code written with mode_wr is used for matches and forces in later cycles only. A match or force in the same cycle as the write uses the previously stored code.
- R5: A force pulse (force_i = 1) with pwm_active_i = 0 applies the stored action exactly as a match would. With pwm_active_i = 1 the force pulse has no effect.
- R6: A match and an honoured force in the same cycle apply the action once. For example, code 01 inverts the level once, not twice.
- R7: A preload write (preload_wr = 1) loads preload_val into the stored level at the next edge. It takes priority over a match or force in the same cycle and works whatever the direction.
- R8: pin_oe equals dir_out. With dir_out = 0, pin_o is 0 and the stored level is kept, so it reappears on pin_o once dir_out returns to 1.
- R9: In a cycle without a preload, a match or an honoured force, the stored level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Write strobe for the action code |
| mode_in | input | 2 | Action code: 00 keep, 01 invert, 10 low, 11 high |
| match_i | input | 1 | Compare-match pulse from the counter |
| force_i | input | 1 | Single-cycle force strobe |
| pwm_active_i | input | 1 | Counter is in a PWM mode (force ignored) |
| preload_wr | input | 1 | Write strobe for the stored level |
| preload_val | input | 1 | Level value to preload |
| dir_out | input | 1 | 1 = pin driven as output, 0 = pin not driven |
| pin_o | output | 1 | Pin level (0 when not driven) |
| pin_oe | output | 1 | Pin driven indication |

## Verification
The assertions check the following on every cycle:
- Each action code produces its level after a match.
- A preload wins over a match or force in the same cycle.
- A force is ignored while PWM mode is indicated.
- The level holds when no event occurs.
- The action code changes only through its write strobe.

The ordering rules can only be shown by the bench's sweeps, because they depend on history across cycles:
- A code written in the same cycle as a match or force is not used for that event.
- A match combined with a force applies the action only once.
- The level kept while the pin is not driven reappears once the pin is driven again.

// File: rtl/cwo_pkg.sv
package cwo_pkg;

    localparam int ACT_W = 2;

    typedef enum logic [ACT_W-1:0] {
        ACT_KEEP = 2'b00,
        ACT_FLIP = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } cmp_act_e;

    typedef struct packed {
        cmp_act_e act;
    } mode_state_t;

    typedef struct packed {
        logic level;
    } level_state_t;

    function automatic logic act_apply(cmp_act_e act, logic cur);
        logic res;
        case (act)
            ACT_FLIP: res = ~cur;
            ACT_LOW:  res = 1'b0;
            ACT_HIGH: res = 1'b1;
            default:  res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/cwo_mode_store.sv
module cwo_mode_store
    import cwo_pkg::*;
#(
    parameter cmp_act_e MODE_RST = ACT_KEEP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [ACT_W-1:0] val_i,
    output cmp_act_e         act_o
);

    mode_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.act = cmp_act_e'(val_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{act: MODE_RST};
        end else begin
            s_q <= s_d;
        end
    end

    assign act_o = s_q.act;

    // The code changes only through a write, and a write is used from the next cycle on.
    assert_mode_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> act_o == cmp_act_e'($past(val_i)));
    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(act_o));

endmodule

// File: rtl/cwo_level_ctrl.sv
module cwo_level_ctrl
    import cwo_pkg::*;
#(
    parameter logic LEVEL_RST = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmp_act_e act_i,
    input  logic     match_i,
    input  logic     force_i,
    input  logic     pwm_i,
    input  logic     pre_wr_i,
    input  logic     pre_val_i,
    output logic     level_o
);

    level_state_t s_d, s_q;
    logic         force_ok;
    logic         fire;

    always_comb begin
        force_ok = force_i & ~pwm_i;
        fire     = match_i | force_ok;
        s_d      = s_q;
        if (pre_wr_i) begin
            s_d.level = pre_val_i;
        end else if (fire) begin
            s_d.level = act_apply(act_i, s_q.level);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{level: LEVEL_RST};
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.level;

    assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_KEEP && !pre_wr_i) |=> $stable(level_o));
    assert_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && act_i == ACT_FLIP && !pre_wr_i) |=> level_o != $past(level_o));
    assert_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && act_i == ACT_LOW && !pre_wr_i) |=> !level_o);
    assert_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && act_i == ACT_HIGH && !pre_wr_i) |=> level_o);
    assert_pwm_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && pwm_i && !match_i && !pre_wr_i) |=> $stable(level_o));
    assert_preload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_wr_i |=> level_o == $past(pre_val_i));
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_wr_i && !match_i && !(force_i && !pwm_i)) |=> $stable(level_o));

endmodule

// File: rtl/cwo_pin_drive.sv
module cwo_pin_drive (
    input  logic level_i,
    input  logic dir_i,
    output logic pin_o,
    output logic pin_oe_o
);

    always_comb begin
        pin_oe_o = dir_i;
        pin_o    = dir_i & level_i;
    end

endmodule

// File: rtl/cmp_wave_out.sv
module cmp_wave_out
    import cwo_pkg::*;
#(
    parameter logic     LEVEL_RST = 1'b0,
    parameter cmp_act_e MODE_RST  = ACT_KEEP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [ACT_W-1:0] mode_in,
    input  logic             match_i,
    input  logic             force_i,
    input  logic             pwm_active_i,
    input  logic             preload_wr,
    input  logic             preload_val,
    input  logic             dir_out,
    output logic             pin_o,
    output logic             pin_oe
);

    cmp_act_e act_q;
    logic     level_q;

    cwo_mode_store #(
        .MODE_RST (MODE_RST)
    ) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (mode_wr),
        .val_i (mode_in),
        .act_o (act_q)
    );

    cwo_level_ctrl #(
        .LEVEL_RST (LEVEL_RST)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act_q),
        .match_i   (match_i),
        .force_i   (force_i),
        .pwm_i     (pwm_active_i),
        .pre_wr_i  (preload_wr),
        .pre_val_i (preload_val),
        .level_o   (level_q)
    );

    cwo_pin_drive u_pin (
        .level_i  (level_q),
        .dir_i    (dir_out),
        .pin_o    (pin_o),
        .pin_oe_o (pin_oe)
    );

    // A driven pin that reads 1 must have its stored level high.
    assert_pin_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && pin_o) |-> level_q);

endmodule

// File: tb/test_cmp_wave_out.sv
module test_cmp_wave_out;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_wr, match_i, force_i, pwm_active_i, preload_wr, preload_val, dir_out;
    logic [1:0] mode_in;
    logic       pin_o, pin_oe;

    int checks = 0;
    int fails  = 0;

    logic       exp_lvl;
    logic [1:0] exp_mode;

    always #4 clk = ~clk;

    cmp_wave_out i_cmp_wave_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .mode_in      (mode_in),
        .match_i      (match_i),
        .force_i      (force_i),
        .pwm_active_i (pwm_active_i),
        .preload_wr   (preload_wr),
        .preload_val  (preload_val),
        .dir_out      (dir_out),
        .pin_o        (pin_o),
        .pin_oe       (pin_oe)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Action codes from R3: 00 keep, 01 invert, 10 low, 11 high.
    function automatic logic model_act(logic [1:0] code, logic cur);
        if (code == 2'd1) return !cur;
        if (code == 2'd2) return 1'b0;
        if (code == 2'd3) return 1'b1;
        return cur;
    endfunction

    task automatic step(input logic mw, input logic [1:0] mv, input logic m, input logic f,
                        input logic p, input logic pw, input logic pv, input logic d);
        logic  fire, nxt;
        string tag;
        @(negedge clk);
        mode_wr = mw; mode_in = mv; match_i = m; force_i = f;
        pwm_active_i = p; preload_wr = pw; preload_val = pv; dir_out = d;
        fire = m | (f & !p);
        nxt  = pw ? pv : (fire ? model_act(exp_mode, exp_lvl) : exp_lvl);
        if (pw)                    tag = "R7 preload";
        else if (mw && fire)       tag = "R4 same-cycle write";
        else if (m && f && !p)     tag = "R6 match with force";
        else if (f && !m)          tag = p ? "R5 force in pwm" : "R5 force";
        else if (m)                tag = (exp_mode == 2'd0) ? "R2 keep" : "R3 match action";
        else                       tag = "R9 idle hold";
        @(posedge clk);
        #2;
        exp_lvl = nxt;
        if (mw) exp_mode = mv;
        check("R8 pin_oe", pin_oe, d);
        check(tag, pin_o, d ? exp_lvl : 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        mode_wr = 0; mode_in = 0; match_i = 0; force_i = 0; pwm_active_i = 0;
        preload_wr = 0; preload_val = 0; dir_out = 1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset pin_o", pin_o, 1'b0);
        check("R1 reset pin_oe", pin_oe, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        exp_lvl  = 1'b0;
        exp_mode = 2'd0;

        // R1: reset code is keep, so a match leaves the level at 0.
        step(0, 2'd0, 1, 0, 0, 0, 0, 1);
        step(0, 2'd0, 0, 1, 0, 0, 0, 1);

        // R8: level prepared while not driven, kept, then shown.
        step(0, 2'd0, 0, 0, 0, 1, 1, 0);
        step(0, 2'd0, 1, 0, 0, 0, 0, 0);
        step(0, 2'd0, 0, 0, 0, 0, 0, 1);

        // Near-exhaustive sweep from each start state (code, level).
        for (int st = 0; st < 8; st++) begin
            step(1, st[2:1], 0, 0, 0, 1, st[0], 1);
            for (int c = 0; c < 512; c++) begin
                step(c[0], c[2:1], c[3], c[4], c[5], c[6], c[7], c[8]);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule